// File: doc/BRIEF.md
# Vector Single-Precision Round-to-Integral Unit

This unit takes a 128-bit vector that holds four IEEE-754 single-precision lanes. It rounds every lane to an integral floating-point value. Each request carries a 32-bit instruction word, and that word selects one of three directed rounding directions: toward plus infinity, toward minus infinity, or toward zero. All four lanes are handled in parallel by mask-and-increment logic that works on the raw bit fields, so no general floating-point adder is needed.

A request is presented with a valid strobe and the source vector. The input is always ready, and each accepted legal request produces a registered result one cycle later, together with the destination register index. A request whose instruction word does not decode to one of the three operations is dropped. In that case the output register keeps its previous value and an illegal-operation flag pulses for one cycle.

Top module: `vec_round_integral`

## Requirements
- R1: An instruction is legal only when bits 31..26 equal 4, bits 20..16 are zero and the extended opcode in bits 10..0 (bit 0 is its least significant bit) is 650 (toward +infinity), 714 (toward -infinity) or 586 (toward zero).
- R2: In the toward +infinity mode, lanes 1.4, 1.5, -1.4 and -1.5 give 2.0, 2.0, -1.0 and -1.0.
- R3: In the toward -infinity mode, lanes 1.4, 1.5, -1.4 and -1.5 give 1.0, 1.0, -2.0 and -2.0.
- R4: In the toward-zero mode, lanes 1.7, 2.5, -1.7 and -2.5 give 1.0, 2.0, -1.0 and -2.0, and no result magnitude exceeds its input magnitude.
- R5: A lane with a biased exponent of 150 or more (already integral), or an infinity, passes through bit-exact.
- R6: A nonzero lane with magnitude below 1.0 becomes ±1.0 (0x3F800000 with the input sign) when the mode rounds away from zero for that sign, and becomes a zero carrying the input sign otherwise. A zero input is returned unchanged with its sign.
- R7: A NaN lane returns a quiet NaN: the input with mantissa bit 22 set, with sign and payload kept.
- R8: For other lanes, the fractional mantissa bits are cleared. One integral unit is added only when the mode rounds away from zero for that sign and a discarded bit was set. A carry out of the mantissa raises the exponent (for example, 7.5 toward +infinity gives 8.0).
- R9: An illegal request produces no output valid, keeps the previous result on result_o and raises illegal_o for exactly one cycle.
- R10: A legal request gives out_valid_o, the result and the destination index from bits 25..21 in the cycle after acceptance, and the lanes are independent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| in_valid_i | input | 1 | Request strobe |
| in_ready_o | output | 1 | Request can be taken (high out of reset) |
| instr_i | input | 32 | Instruction word selecting the operation |
| src_i | input | 128 | Source vector, lane 0 in bits 31..0 |
| out_valid_o | output | 1 | Result valid, one cycle after a legal request |
| dst_idx_o | output | 5 | Destination register index of the result |
| result_o | output | 128 | Rounded vector |
| illegal_o | output | 1 | One-cycle pulse for a dropped request |

## Verification
A wrong decode shows up in the cycle after the request. It appears either as a rounding in the wrong direction on one or more lanes, or as a swap between out_valid_o and illegal_o. Faults in the lane datapath, such as a wrong fraction mask, a lost carry into the exponent, or a dropped sign on a zero, appear as wrong lane bits in that same cycle. A fault in the output register's hold behaviour appears as a changed result_o right after a dropped request. Random lanes spread over the exponents where the fraction boundary moves are checked against a bench model built on integer arithmetic, alongside the stated corner values.

// File: rtl/vec_round_pkg.sv
package vec_round_pkg;
  localparam int LANE_W = 32;
  localparam int EXP_W  = 8;
  localparam int MAN_W  = 23;
  localparam int BIAS   = 127;

  localparam logic [5:0]  PRIMARY_OP = 6'd4;
  localparam logic [10:0] XO_CEIL    = 11'd650;
  localparam logic [10:0] XO_FLOOR   = 11'd714;
  localparam logic [10:0] XO_TRUNC   = 11'd586;

  typedef enum logic [1:0] {
    RND_CEIL  = 2'd0,
    RND_FLOOR = 2'd1,
    RND_TRUNC = 2'd2
  } rnd_mode_e;
endpackage

// File: rtl/vec_round_decode.sv
module vec_round_decode
  import vec_round_pkg::*;
(
  input  logic [31:0] instr_i,
  output logic        legal_o,
  output rnd_mode_e   mode_o
);
  logic [5:0]  prim;
  logic [4:0]  mid;
  logic [10:0] xo;
  logic        form_ok;

  assign prim    = instr_i[31:26];
  assign mid     = instr_i[20:16];
  assign xo      = instr_i[10:0];
  assign form_ok = (prim == PRIMARY_OP) && (mid == '0);

  always_comb begin
    legal_o = 1'b0;
    mode_o  = RND_TRUNC;
    if (form_ok) begin
      unique case (xo)
        XO_CEIL:  begin legal_o = 1'b1; mode_o = RND_CEIL;  end
        XO_FLOOR: begin legal_o = 1'b1; mode_o = RND_FLOOR; end
        XO_TRUNC: begin legal_o = 1'b1; mode_o = RND_TRUNC; end
        default:  legal_o = 1'b0;
      endcase
    end
  end

  // R1: a legal decode always implies the primary opcode and zero middle field
  always_comb begin
    p_legal_form_r1: assert (!legal_o || form_ok);
  end
endmodule

// File: rtl/vec_round_lane.sv
module vec_round_lane
  import vec_round_pkg::*;
(
  input  rnd_mode_e         mode_i,
  input  logic [LANE_W-1:0] a_i,
  output logic [LANE_W-1:0] y_o
);
  localparam logic [EXP_W-1:0]  EXP_ALL  = '1;
  localparam logic [EXP_W-1:0]  EXP_ONE  = EXP_W'(BIAS);
  localparam logic [EXP_W-1:0]  EXP_INTG = EXP_W'(BIAS + MAN_W);
  localparam logic [LANE_W-2:0] MAG_ONE  = {EXP_ONE, {MAN_W{1'b0}}};

  logic                 sgn;
  logic [EXP_W-1:0]     expo;
  logic [MAN_W-1:0]     man;
  logic [MAN_W-1:0]     frac_mask;
  logic [EXP_W-1:0]     shamt;
  logic                 away;
  logic                 lost;
  logic [LANE_W-2:0]    mag;

  assign sgn  = a_i[LANE_W-1];
  assign expo = a_i[LANE_W-2 -: EXP_W];
  assign man  = a_i[MAN_W-1:0];
  assign away = (mode_i == RND_CEIL && !sgn) || (mode_i == RND_FLOOR && sgn);

  always_comb begin
    shamt     = expo - EXP_ONE;
    frac_mask = '0;
    lost      = 1'b0;
    mag       = a_i[LANE_W-2:0];
    y_o       = a_i;
    if (expo == EXP_ALL) begin
      if (man != '0) y_o = a_i | (LANE_W'(1) << (MAN_W - 1));
    end else if (expo >= EXP_INTG) begin
      y_o = a_i;
    end else if (expo < EXP_ONE) begin
      if (a_i[LANE_W-2:0] != '0)
        y_o = away ? {sgn, MAG_ONE} : {sgn, {(LANE_W-1){1'b0}}};
    end else begin
      frac_mask = {MAN_W{1'b1}} >> shamt;
      lost      = |(man & frac_mask);
      mag       = {expo, man & ~frac_mask};
      // unit increment; mantissa carry ripples into the exponent field
      if (away && lost)
        mag = mag + {{EXP_W{1'b0}}, frac_mask} + (LANE_W-1)'(1);
      y_o = {sgn, mag};
    end
  end

  always_comb begin
    // R4: truncation never grows a non-NaN magnitude
    p_trunc_shrink_r4: assert (mode_i != RND_TRUNC || expo == EXP_ALL ||
                               y_o[LANE_W-2:0] <= a_i[LANE_W-2:0]);
    // R6: sign survives for every lane
    p_sign_kept_r6: assert (y_o[LANE_W-1] == sgn);
  end
endmodule

// File: rtl/vec_round_integral.sv
module vec_round_integral
  import vec_round_pkg::*;
#(
  parameter int LANES = 4,
  localparam int VEC_W = LANES * LANE_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  output logic             in_ready_o,
  input  logic [31:0]      instr_i,
  input  logic [VEC_W-1:0] src_i,
  output logic             out_valid_o,
  output logic [4:0]       dst_idx_o,
  output logic [VEC_W-1:0] result_o,
  output logic             illegal_o
);
  logic             legal;
  rnd_mode_e        mode;
  logic [VEC_W-1:0] rounded;
  logic             take;

  vec_round_decode u_decode (
    .instr_i (instr_i),
    .legal_o (legal),
    .mode_o  (mode)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    vec_round_lane u_lane (
      .mode_i (mode),
      .a_i    (src_i[g*LANE_W +: LANE_W]),
      .y_o    (rounded[g*LANE_W +: LANE_W])
    );
  end

  assign in_ready_o = 1'b1;
  assign take       = in_valid_i && legal;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      illegal_o   <= 1'b0;
      dst_idx_o   <= '0;
      result_o    <= '0;
    end else begin
      out_valid_o <= take;
      illegal_o   <= in_valid_i && !legal;
      if (take) begin
        dst_idx_o <= instr_i[25:21];
        result_o  <= rounded;
      end
    end
  end

  p_excl_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(out_valid_o && illegal_o));
  p_drop_flag_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && !legal) |=> (illegal_o && !out_valid_o));
  p_drop_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && !legal) |=> $stable(result_o));
  p_issue_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && legal) |=> (out_valid_o && dst_idx_o == $past(instr_i[25:21])));
  p_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (illegal_o && !in_valid_i) |=> !illegal_o);
endmodule

// File: tb/vec_round_integral_bench.sv
module vec_round_integral_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [31:0]  instr = '0;
  logic [127:0] src = '0;
  logic         out_valid;
  logic [4:0]   dst_idx;
  logic [127:0] result;
  logic         illegal;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  always #5 clk = ~clk;

  vec_round_integral u_vec_round_integral (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .in_valid_i  (in_valid),
    .in_ready_o  (in_ready),
    .instr_i     (instr),
    .src_i       (src),
    .out_valid_o (out_valid),
    .dst_idx_o   (dst_idx),
    .result_o    (result),
    .illegal_o   (illegal)
  );

  localparam logic [10:0] XC = 11'd650, XF = 11'd714, XT = 11'd586;

  function automatic logic [31:0] mk_instr(input logic [10:0] xo, input logic [4:0] d,
                                           input logic [4:0] s);
    return (32'd4 << 26) | (32'(d) << 21) | (32'(s) << 11) | 32'(xo);
  endfunction

  // bench model: integer part via shifts, re-encoded by leading-one search
  function automatic logic [31:0] ref_round(input logic [31:0] a, input int md);
    logic s; int e; logic [23:0] full; logic [24:0] ip; int sh, p; bit up, fnz;
    s = a[31]; e = int'(a[30:23]);
    up = (md == 0 && !s) || (md == 1 && s);
    if (e == 255) return (a[22:0] != 0) ? (a | 32'h0040_0000) : a;
    if (e >= 150 || a[30:0] == 0) return a;
    if (e < 127) return up ? {s, 31'h3F80_0000} : {s, 31'h0};
    sh = 150 - e;
    full = {1'b1, a[22:0]};
    ip = 25'(full >> sh);
    fnz = (25'(full) != (ip << sh));
    if (up && fnz) ip = ip + 1;
    p = 0;
    for (int i = 0; i < 25; i++) if (ip[i]) p = i;
    return {s, 8'(127 + p), 23'((ip << (23 - p)) & 25'h7F_FFFF)};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [127:0] got,
                     input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic issue(input logic [31:0] ins, input logic [127:0] v);
    @(negedge clk);
    in_valid = 1'b1; instr = ins; src = v;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic run_legal(input logic [10:0] xo, input int md, input logic [127:0] v,
                           input logic [127:0] exp, input string req);
    logic [4:0] d;
    d = 5'($urandom_range(0, 31));
    issue(mk_instr(xo, d, 5'd1), v);
    chk(out_valid && !illegal, req, {126'b0, out_valid, illegal}, 128'h2);
    chk(dst_idx == d, "R10", 128'(dst_idx), 128'(d));
    chk(result == exp, req, result, exp);
  endtask

  function automatic logic [127:0] ref_vec(input logic [127:0] v, input int md);
    logic [127:0] r;
    for (int l = 0; l < 4; l++) r[l*32 +: 32] = ref_round(v[l*32 +: 32], md);
    return r;
  endfunction

  initial begin
    #2_000_000;
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: got hang expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [127:0] prev, v;
    logic [10:0] xos [3];
    void'($urandom(32'd20240517));
    xos[0] = XC; xos[1] = XF; xos[2] = XT;
    repeat (3) @(negedge clk);
    chk(!out_valid && !illegal && result == '0 && in_ready, "R10 reset",
        {result[125:0], out_valid, illegal}, 128'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // lanes: 1.4, 1.5, -1.4, -1.5 (lane 0 lowest)
    v = {32'hBFC0_0000, 32'hBFB3_3333, 32'h3FC0_0000, 32'h3FB3_3333};
    run_legal(XC, 0, v, {32'hBF80_0000, 32'hBF80_0000, 32'h4000_0000, 32'h4000_0000}, "R2");
    run_legal(XF, 1, v, {32'hC000_0000, 32'hC000_0000, 32'h3F80_0000, 32'h3F80_0000}, "R3");
    // 1.7, 2.5, -1.7, -2.5
    v = {32'hC020_0000, 32'hBFD9_999A, 32'h4020_0000, 32'h3FD9_999A};
    run_legal(XT, 2, v, {32'hC000_0000, 32'hBF80_0000, 32'h4000_0000, 32'h3F80_0000}, "R4");
    // R5: 2^23+1, -inf, +inf, 1e10
    v = {32'h5015_02F9, 32'h7F80_0000, 32'hFF80_0000, 32'h4B00_0001};
    run_legal(XC, 0, v, v, "R5");
    // R6: 0.3, -0.3, -0.0, tiny denormal
    v = {32'h0000_0001, 32'h8000_0000, 32'hBE99_999A, 32'h3E99_999A};
    run_legal(XC, 0, v, {32'h3F80_0000, 32'h8000_0000, 32'h8000_0000, 32'h3F80_0000}, "R6 ceil");
    run_legal(XF, 1, v, {32'h0000_0000, 32'h8000_0000, 32'hBF80_0000, 32'h0000_0000}, "R6 floor");
    // R7: signalling NaN, quiet NaN with payload, negative sNaN
    v = {32'h3F80_0000, 32'hFF80_0ABC, 32'hFFC1_2345, 32'h7F80_0001};
    run_legal(XT, 2, v, {32'h3F80_0000, 32'hFFC0_0ABC, 32'hFFC1_2345, 32'h7FC0_0001}, "R7");
    // R8: 7.5 ceil -> 8.0, -7.5 floor -> -8.0 via exponent carry
    v = {32'h4B7F_FFFF, 32'hC0F0_0000, 32'h40F0_0000, 32'h40F0_0000};
    run_legal(XC, 0, v, {32'h4B7F_FFFF, 32'hC0E0_0000, 32'h4100_0000, 32'h4100_0000}, "R8");
    run_legal(XF, 1, v, {32'h4B7F_FFFF, 32'hC100_0000, 32'h40E0_0000, 32'h40E0_0000}, "R8");

    // R9 / R1: illegal forms keep result and pulse the flag once
    begin
      logic [31:0] bad [4];
      bad[0] = mk_instr(11'd651, 5'd2, 5'd1);
      bad[1] = mk_instr(XC, 5'd2, 5'd1) | (32'd1 << 16);
      bad[2] = (mk_instr(XF, 5'd2, 5'd1) & 32'h03FF_FFFF) | (32'd5 << 26);
      bad[3] = mk_instr(11'd650 << 1, 5'd2, 5'd1);
      for (int k = 0; k < 4; k++) begin
        prev = result;
        issue(bad[k], {4{32'h3FC0_0000}});
        chk(illegal && !out_valid, "R1 R9 flag", {126'b0, out_valid, illegal}, 128'h1);
        chk(result == prev, "R9 hold", result, prev);
        @(negedge clk);
        chk(!illegal, "R9 pulse", 128'(illegal), 128'h0);
      end
    end

    // random lanes around the fraction boundary, plus occasional illegal codes
    for (int it = 0; it < 600; it++) begin
      int md;
      for (int l = 0; l < 4; l++) begin
        logic [7:0] e;
        e = ($urandom_range(0, 9) == 0) ? 8'($urandom_range(0, 255))
                                         : 8'(110 + $urandom_range(0, 50));
        v[l*32 +: 32] = {1'($urandom), e, 23'($urandom)};
      end
      md = $urandom_range(0, 2);
      if ($urandom_range(0, 7) == 0) begin
        prev = result;
        issue(mk_instr(11'($urandom) | 11'h400, 5'd3, 5'd4), v);
        chk(illegal && !out_valid && result == prev, "R9 random", result, prev);
      end else begin
        run_legal(xos[md], md, v, ref_vec(v, md),
                  md == 0 ? "R2 R8 R10 random" : md == 1 ? "R3 R8 R10 random" : "R4 R8 R10 random");
      end
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule